// File: doc/BRIEF.md
# Keyed Configuration Register File

This block holds the configuration bytes of a peripheral I/O controller behind a three-port host window on a simple byte-wide I/O bus. The three ports sit at consecutive I/O addresses. The first port takes a key byte. The second port takes a register index. The third port reads or writes the register that the index selects. Access stays closed until the host writes the correct key. The accepted key depends on a strap pin that is captured at cold reset. Access closes again when the host writes any other byte to the key port, or when it sets the lock bit held in one of the configuration registers.

Every configuration byte drives a parallel output bus, which the rest of the controller consumes. A cold reset loads the defaults, and one register takes its default from strap pins. A warm reset only closes access and leaves the contents alone. Each bus access lasts one clock: `io_wr` or `io_rd` is high for one cycle. Writes take effect on that clock edge. Read data is combinational during the strobe.

Top module: `cfgkey_regfile`

## Requirements
- R1: The key port is at I/O address 250H, the index port at 251H and the data port at 252H. Accesses to any other address have no effect, and only a read of the data port may raise `rdata_oe`.
- R2: The strap `strap_keysel`, sampled at cold reset, selects the accepted key: 1 selects 89H and 0 selects 88H. Writing the selected key to the key port opens access, and writing the other value does not.
- R3: Writing to the key port any byte other than the selected key closes access from the next cycle.
- R4: While access is closed, writes to the index port and the data port change nothing. A read of the data port returns FFH with `rdata_oe` low.
- R5: While access is open, the index port stores the written byte. An index from 00H to 0BH selects register 0 to 11. A data port write updates the selected register, and a data port read returns it with `rdata_oe` high.
- R6: While access is open, an index of 0CH or above makes data port writes change nothing, and data port reads return 00H with `rdata_oe` high.
- R7: A data port write to register 9 with bit 6 set stores the byte and closes access from the next cycle. Access stays closed, with the bit still set, until the selected key is written again.
- R8: A cold reset (`rst_cold` high) loads register 0 from `strap_val` and every other register i with i×11H. It also clears the index to 00H and closes access.
- R9: A warm reset (`rst_warm` high, `rst_cold` low) leaves all register contents unchanged, clears the index to 00H and closes access. Cold reset has priority over warm reset.
- R10: `cfg_out[8i+7:8i]` carries register i and shows a write from the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold | input | 1 | Synchronous cold reset, active high; restores defaults |
| rst_warm | input | 1 | Synchronous warm reset, active high; closes access only |
| strap_keysel | input | 1 | Key select strap, captured at cold reset |
| strap_val | input | 8 | Strap levels loaded into register 0 at cold reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| rdata_oe | output | 1 | High when the block drives read data |
| cfg_out | output | 96 | All configuration registers, register i at bits 8i+7:8i |

## Verification
If the open/closed state is wrong, the next data port read shows it at once. A closed gate that should be open returns FFH with `rdata_oe` low. An open gate that should be closed drives data. A wrong index shows as the wrong byte on that read, or as a change in the wrong lane of `cfg_out` one edge after a data write. A lost or corrupted register shows on `cfg_out` after every warm reset. A strap that was captured wrongly shows on the first unlock attempt, because the wrong key gets accepted.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_KEY  = 2'd1,
        PORT_IDX  = 2'd2,
        PORT_DAT  = 2'd3
    } port_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        port_e             port;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    localparam logic [DATA_W-1:0] KEY_SEL1 = 8'h89;
    localparam logic [DATA_W-1:0] KEY_SEL0 = 8'h88;

    function automatic logic [DATA_W-1:0] key_for(input logic sel);
        return sel ? KEY_SEL1 : KEY_SEL0;
    endfunction

    // Default contents for register i (i >= 1): i times 11H.
    function automatic logic [DATA_W-1:0] reg_default(input int i);
        return DATA_W'(i * 17);
    endfunction

endpackage

// File: rtl/cfgkey_decode.sv
module cfgkey_decode
    import cfgkey_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0250
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output bus_req_t          req
);
    localparam logic [ADDR_W-1:0] ADDR_IDX = BASE_ADDR + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_DAT = BASE_ADDR + ADDR_W'(2);

    port_e port_d;

    always_comb begin
        if (io_addr == BASE_ADDR)     port_d = PORT_KEY;
        else if (io_addr == ADDR_IDX) port_d = PORT_IDX;
        else if (io_addr == ADDR_DAT) port_d = PORT_DAT;
        else                          port_d = PORT_NONE;
    end

    always_comb begin
        req.wr   = io_wr;
        req.rd   = io_rd;
        req.port = port_d;
        req.data = io_wdata;
    end
endmodule

// File: rtl/cfgkey_gate.sv
module cfgkey_gate
    import cfgkey_pkg::*;
(
    input  logic              clk,
    input  logic              rst_cold,
    input  logic              rst_warm,
    input  logic              strap_keysel,
    input  bus_req_t          req,
    input  logic              lock_hit,
    output logic              unlocked,
    output logic [DATA_W-1:0] idx
);
    logic key_sel_q;
    logic key_wr;
    logic idx_wr;

    assign key_wr = req.wr && (req.port == PORT_KEY);
    assign idx_wr = req.wr && (req.port == PORT_IDX) && unlocked;

    // Strap capture: only a cold reset samples the pin.
    always_ff @(posedge clk) begin
        if (rst_cold) key_sel_q <= strap_keysel;
    end

    always_ff @(posedge clk) begin
        if (rst_cold || rst_warm) begin
            unlocked <= 1'b0;
            idx      <= '0;
        end else begin
            if (key_wr)        unlocked <= (req.data == key_for(key_sel_q));
            else if (lock_hit) unlocked <= 1'b0;
            if (idx_wr)        idx <= req.data;
        end
    end
endmodule

// File: rtl/cfgkey_bank.sv
module cfgkey_bank
    import cfgkey_pkg::*;
#(
    parameter int NREG     = 12,
    parameter int LOCK_IDX = 9,
    parameter int LOCK_BIT = 6
) (
    input  logic                   clk,
    input  logic                   rst_cold,
    input  logic [DATA_W-1:0]      strap_val,
    input  bus_req_t               req,
    input  logic                   unlocked,
    input  logic [DATA_W-1:0]      idx,
    output logic [NREG*DATA_W-1:0] regs_flat,
    output logic [DATA_W-1:0]      rdata,
    output logic                   rdata_oe,
    output logic                   lock_hit
);
    logic [DATA_W-1:0] cr [NREG];
    logic              wr_en;
    logic              rd_en;
    logic              in_range;

    assign in_range = ({24'd0, idx} < 32'(NREG));
    assign wr_en    = req.wr && (req.port == PORT_DAT) && unlocked && in_range;
    assign rd_en    = req.rd && (req.port == PORT_DAT) && unlocked;
    assign lock_hit = wr_en && (idx == DATA_W'(LOCK_IDX)) && req.data[LOCK_BIT];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DATA_W-1:0] dflt;
        if (g == 0) begin : g_strap
            assign dflt = strap_val;
        end else begin : g_const
            assign dflt = reg_default(g);
        end

        always_ff @(posedge clk) begin
            if (rst_cold)                           cr[g] <= dflt;
            else if (wr_en && idx == DATA_W'(g))    cr[g] <= req.data;
        end

        assign regs_flat[g*DATA_W +: DATA_W] = cr[g];
    end

    always_comb begin
        rdata    = '1;
        rdata_oe = 1'b0;
        if (rd_en) begin
            rdata_oe = 1'b1;
            rdata    = '0;
            for (int i = 0; i < NREG; i++) begin
                if (idx == DATA_W'(i)) rdata = cr[i];
            end
        end
    end
endmodule

// File: rtl/cfgkey_regfile.sv
module cfgkey_regfile
    import cfgkey_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0250,
    parameter int                NREG      = 12,
    parameter int                LOCK_IDX  = 9,
    parameter int                LOCK_BIT  = 6,
    localparam int               CFG_W     = NREG * DATA_W
) (
    input  logic              clk,
    input  logic              rst_cold,
    input  logic              rst_warm,
    input  logic              strap_keysel,
    input  logic [7:0]        strap_val,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              rdata_oe,
    output logic [CFG_W-1:0]  cfg_out
);
    bus_req_t          req;
    logic              unlocked_w;
    logic [DATA_W-1:0] idx_w;
    logic              lock_hit_w;

    cfgkey_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_wdata(io_wdata),
        .req     (req)
    );

    cfgkey_gate u_gate (
        .clk         (clk),
        .rst_cold    (rst_cold),
        .rst_warm    (rst_warm),
        .strap_keysel(strap_keysel),
        .req         (req),
        .lock_hit    (lock_hit_w),
        .unlocked    (unlocked_w),
        .idx         (idx_w)
    );

    cfgkey_bank #(.NREG(NREG), .LOCK_IDX(LOCK_IDX), .LOCK_BIT(LOCK_BIT)) u_bank (
        .clk      (clk),
        .rst_cold (rst_cold),
        .strap_val(strap_val),
        .req      (req),
        .unlocked (unlocked_w),
        .idx      (idx_w),
        .regs_flat(cfg_out),
        .rdata    (io_rdata),
        .rdata_oe (rdata_oe),
        .lock_hit (lock_hit_w)
    );
endmodule

// File: rtl/cfgkey_chk.sv
module cfgkey_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0250,
    parameter int                NREG      = 12,
    parameter int                LOCK_IDX  = 9,
    parameter int                LOCK_BIT  = 6
) (
    input logic              clk,
    input logic              rst_cold,
    input logic              rst_warm,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              rdata_oe,
    input logic [NREG*8-1:0] cfg_out,
    input logic              unlocked,
    input logic [7:0]        idx
);
    localparam logic [ADDR_W-1:0] A_KEY = BASE_ADDR;
    localparam logic [ADDR_W-1:0] A_DAT = BASE_ADDR + ADDR_W'(2);

    logic seen_cold;
    always_ff @(posedge clk) begin
        if (rst_cold) seen_cold <= 1'b1;
        else if (seen_cold !== 1'b1) seen_cold <= 1'b0;
    end

    // R1: only a data port read drives the bus
    a_r1_oe_only_data: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        rdata_oe |-> (io_rd && io_addr == A_DAT));

    // R4: closed gate never drives data
    a_r4_locked_quiet: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        !unlocked |-> (!rdata_oe && io_rdata == 8'hFF));

    // R4: closed gate keeps contents on data writes
    a_r4_locked_no_write: assert property (@(posedge clk) disable iff (rst_cold || rst_warm || seen_cold !== 1'b1)
        (!unlocked && io_wr && io_addr == A_DAT) |=> (cfg_out == $past(cfg_out)));

    // R3: wrong key closes access next cycle
    a_r3_bad_key_locks: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        (io_wr && io_addr == A_KEY && io_wdata != 8'h89 && io_wdata != 8'h88) |=> !unlocked);

    // R6: out-of-range index reads zero
    a_r6_oob_zero: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        (rdata_oe && {24'd0, idx} >= 32'(NREG)) |-> (io_rdata == 8'h00));

    // R7: lock bit write closes access next cycle
    a_r7_lock_bit: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        (unlocked && io_wr && io_addr == A_DAT && idx == 8'(LOCK_IDX) && io_wdata[LOCK_BIT])
        |=> !unlocked);

    // R9: warm reset keeps contents and closes access
    a_r9_warm_keeps: assert property (@(posedge clk) disable iff (rst_cold || seen_cold !== 1'b1)
        rst_warm |=> (cfg_out == $past(cfg_out) && !unlocked && idx == 8'h00));
endmodule

bind cfgkey_regfile cfgkey_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NREG(NREG),
    .LOCK_IDX(LOCK_IDX), .LOCK_BIT(LOCK_BIT)
) u_chk (
    .clk     (clk),
    .rst_cold(rst_cold),
    .rst_warm(rst_warm),
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .rdata_oe(rdata_oe),
    .cfg_out (cfg_out),
    .unlocked(unlocked_w),
    .idx     (idx_w)
);

// File: tb/sim_cfgkey_regfile.sv
module sim_cfgkey_regfile;
    localparam int NREG = 12;
    localparam logic [15:0] A_KEY = 16'h0250;
    localparam logic [15:0] A_IDX = 16'h0251;
    localparam logic [15:0] A_DAT = 16'h0252;

    logic        clk = 1'b0;
    logic        rst_cold = 1'b0, rst_warm = 1'b0;
    logic        strap_keysel = 1'b1;
    logic [7:0]  strap_val = 8'hA5;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        rdata_oe;
    logic [NREG*8-1:0] cfg_out;

    always #2.5 clk = ~clk;

    cfgkey_regfile u0 (
        .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm),
        .strap_keysel(strap_keysel), .strap_val(strap_val),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .rdata_oe(rdata_oe), .cfg_out(cfg_out)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Bench model, built from the requirements
    logic [7:0] m_reg [NREG];
    logic       m_unlk;
    logic [7:0] m_idx;
    logic [7:0] m_key;

    function automatic logic [NREG*8-1:0] m_flat();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m_reg[i];
        return v;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_cold();
        for (int i = 0; i < NREG; i++) m_reg[i] = (i == 0) ? strap_val : 8'(i * 17);
        m_unlk = 1'b0; m_idx = 8'h00;
        m_key = strap_keysel ? 8'h89 : 8'h88;
    endtask

    task automatic do_cold();
        @(negedge clk); rst_cold = 1'b1;
        @(negedge clk); rst_cold = 1'b0;
        m_cold();
    endtask

    task automatic do_warm();
        @(negedge clk); rst_warm = 1'b1;
        @(negedge clk); rst_warm = 1'b0;
        m_unlk = 1'b0; m_idx = 8'h00;
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
        if (a == A_KEY) m_unlk = (d == m_key);
        else if (a == A_IDX && m_unlk) m_idx = d;
        else if (a == A_DAT && m_unlk && m_idx < NREG) begin
            m_reg[m_idx] = d;
            if (m_idx == 8'd9 && d[6]) m_unlk = 1'b0;
        end
    endtask

    task automatic bus_rd(input logic [15:0] a, input string req);
        logic [8:0] exp;
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        #1;
        if (a != A_DAT || !m_unlk) exp = {1'b0, 8'hFF};
        else if (m_idx < NREG)     exp = {1'b1, m_reg[m_idx]};
        else                       exp = {1'b1, 8'h00};
        check(req, {119'd0, rdata_oe, io_rdata}, {119'd0, exp});
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic chk_cfg(input string req);
        #1 check(req, 128'(cfg_out), 128'(m_flat()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R8: cold reset state
        do_cold();
        chk_cfg("R8 cold defaults");
        bus_rd(A_DAT, "R4 locked read after reset");
        // R4: locked writes ignored
        bus_wr(A_IDX, 8'h03); bus_wr(A_DAT, 8'h5A);
        chk_cfg("R4 locked write ignored");
        // R2: wrong-polarity key does not open
        bus_wr(A_KEY, 8'h88);
        bus_rd(A_DAT, "R2 other key stays closed");
        bus_wr(A_KEY, 8'h89);
        bus_rd(A_DAT, "R2 R5 open read reg0 strap");
        // R5/R10
        bus_wr(A_IDX, 8'h0B); bus_wr(A_DAT, 8'h3C);
        chk_cfg("R10 lane 11 update");
        bus_rd(A_DAT, "R5 read back reg 11");
        // R6
        bus_wr(A_IDX, 8'h0C); bus_wr(A_DAT, 8'hEE);
        chk_cfg("R6 oob write ignored");
        bus_rd(A_DAT, "R6 oob read zero");
        // R1: neighbour addresses
        bus_wr(16'h0253, 8'h00); bus_wr(16'h024F, 8'h00);
        bus_rd(16'h0251, "R1 index port read not driven");
        bus_rd(A_DAT, "R1 neighbours no effect");
        // R7
        bus_wr(A_IDX, 8'h09); bus_wr(A_DAT, 8'h40);
        chk_cfg("R7 lock bit stored");
        bus_rd(A_DAT, "R7 closed after lock bit");
        bus_wr(A_IDX, 8'h01); bus_wr(A_DAT, 8'h77);
        chk_cfg("R7 lock holds");
        bus_wr(A_KEY, 8'h89);
        bus_rd(A_DAT, "R7 reopened reg9 still set");
        // R3
        bus_wr(A_KEY, 8'h12);
        bus_rd(A_DAT, "R3 wrong key closes");
        // R9
        bus_wr(A_KEY, 8'h89); bus_wr(A_IDX, 8'h02); bus_wr(A_DAT, 8'h99);
        do_warm();
        chk_cfg("R9 warm keeps contents");
        bus_rd(A_DAT, "R9 warm closes");
        bus_wr(A_KEY, 8'h89);
        bus_rd(A_DAT, "R9 index cleared to 0");
        // R2: other strap polarity
        strap_keysel = 1'b0; strap_val = 8'h3E;
        do_cold();
        chk_cfg("R8 second strap");
        bus_wr(A_KEY, 8'h89);
        bus_rd(A_DAT, "R2 89H rejected with strap 0");
        bus_wr(A_KEY, 8'h88);
        bus_rd(A_DAT, "R2 88H accepted with strap 0");
        // Random mix
        for (int n = 0; n < 2000; n++) begin
            int sel;
            sel = int'($urandom_range(0, 99));
            if (sel < 12)      bus_wr(A_KEY, ($urandom_range(0, 3) != 0) ? m_key : 8'($urandom));
            else if (sel < 32) bus_wr(A_IDX, 8'($urandom_range(0, 14)));
            else if (sel < 55) bus_wr(A_DAT, 8'($urandom) & 8'hBF | ($urandom_range(0, 9) == 0 ? 8'h40 : 8'h00));
            else if (sel < 85) bus_rd(A_DAT, "R5 random read");
            else if (sel < 92) bus_rd(16'(A_KEY + 16'($urandom_range(0, 1))), "R1 random other read");
            else if (sel < 96) bus_wr(16'(16'h0240 + 16'($urandom_range(0, 15)) * 16'h2), 8'($urandom));
            else               do_warm();
            chk_cfg("R10 random cfg_out");
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule